// File: doc/BRIEF.md
# Byte-Wide Up/Down Counter Channel

This block is one 24-bit up/down counter channel reached through an 8-bit host port. The port has two addresses: a data address and a control address. A write to the data address stores one byte of the preset register. A read from the data address returns one byte of the output latch. A shared byte pointer picks the byte, least significant first, and moves on after every data access. A write to the control address is a command. A read from the control address returns a status byte.

The host cannot write the counter directly. To set it, software fills the preset register and then issues a transfer command. To read it, software issues a snapshot command, which copies the live counter into the output latch, and then reads three bytes. The count strobe and its direction come from a separate decoder. An index input can also reload the counter from the preset register, on the edge that the index polarity selects. A master-hold input freezes counting.

There are four count modes. Each mode uses the carry and borrow flags, so software can tell a wrap and extend the range by one bit.

Top module: `bytewide_counter_ch`

## Requirements
- R1: After reset the counter, preset and latch are 0, the byte pointer is 0 and the status byte reads 0x00. After reset the mode is normal, counting is disabled and the index polarity selects the falling edge.
- R2: Data-port accesses move one byte at a time, least significant byte first, and the pointer advances 0, 1, 2 and back to 0. Control byte 0x01 resets the pointer. Control byte 0x11 resets the pointer and copies the counter into the latch. The latch keeps that copy while the counter moves on.
- R3: Control byte 0x08 copies the preset register into the counter at the write edge. This is the only host path that loads the counter.
- R4: The count strobe only counts while control-group-2 bit 0 is 1, set with a byte of the form 0x40 | cfg. After reset this bit is 0, and strobes are then ignored.
- R5: In mode 0 (set with control byte 0x20 | mode<<1), the counter wraps. Counting up from 0xFFFFFF gives 0 and sets carry. Counting down from 0 gives 0xFFFFFF and sets borrow.
- R6: In mode 1 the counter does not move when counting up at the preset value, and carry is set. It does not move when counting down at 0, and borrow is set.
- R7: In mode 2 a wrap behaves as in mode 0, and then every further strobe is ignored until the next load from the preset register.
- R8: In mode 3, counting up at the preset value gives 0 and sets carry. Counting down at 0 reloads the preset value and sets borrow.
- R9: Control bytes 0x02 and 0x04 clear carry and borrow and leave the error flag set. Control byte 0x06 clears the error flag. Each clear is visible in the cycle after the write.
- R10: The status byte has borrow in bit 0, carry in bit 1, error in bit 4 and direction in bit 5. Direction is 1 after an up step and 0 after a down step. A cycle with the noise input high sets the error flag, and the flag stays set.
- R11: When control-group-2 bit 1 is 0, an index edge loads the preset value into the counter. When that bit is 1, index edges have no effect. Control-group-3 bit 1 selects the edge: 0 for falling, 1 for rising (0x60 | cfg).
- R12: While the hold input is high, count strobes have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe; a read from the data address advances the pointer |
| bus_ctl | input | 1 | Address select: 1 is the control/status address, 0 is the data address |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte: the latch byte at the pointer, or the status byte |
| cnt_step | input | 1 | Count strobe from the decoder |
| cnt_up | input | 1 | Count direction, 1 for up |
| index_in | input | 1 | Index signal level |
| noise_in | input | 1 | Noise-error indication from the decoder |
| hold_rst | input | 1 | Master hold; counting is suppressed while it is high |

## Verification
The bench goes after each mode's boundary: the top of the count range and zero in mode 0, the preset value in modes 1 and 3, and the halt after a wrap in mode 2. A design with an off-by-one terminal compare would show a wrong count or a missing flag. It also checks that a snapshot holds after the counter moves on, that 0x01 returns the pointer to the low byte, and that a flag clear leaves the error flag alone. A shared pointer bug would show up as shuffled bytes, and a crossed clear as a lost error flag. Index loads are tested on both polarities and with the active-low enable off, along with the hold input and the disabled count inputs. A design that ignored any of these gates would show a counter that moved when it should have stayed.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    localparam int BYTE_W  = 8;
    localparam int NBYTES  = 3;
    localparam int CNT_W   = BYTE_W * NBYTES;
    localparam int PTR_W   = $clog2(NBYTES);
    localparam int CFG_W   = 3;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    localparam int ST_BORROW = 0;
    localparam int ST_CARRY  = 1;
    localparam int ST_ERR    = 4;
    localparam int ST_DIR    = 5;

    typedef enum logic [1:0] {
        CM_NORMAL = 2'd0,
        CM_RANGE  = 2'd1,
        CM_NOREC  = 2'd2,
        CM_MODN   = 2'd3
    } count_mode_e;

    typedef enum logic [2:0] {
        GRP_ACTION = 3'b000,
        GRP_MODE   = 3'b001,
        GRP_IOCTL  = 3'b010,
        GRP_INDEX  = 3'b011
    } cmd_group_e;

    typedef struct packed {
        logic             ptr_rst;
        logic             snap;
        logic             load;
        logic             clr_flags;
        logic             clr_err;
        logic             wr_mode;
        logic             wr_ioctl;
        logic             wr_index;
        logic [CFG_W-1:0] cfg;
    } cmd_t;

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             carry;
        logic             borrow;
        logic             halt;
    } step_res_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c = '0;
        c.cfg = b[CFG_W-1:0];
        case (cmd_group_e'(b[7:5]))
            GRP_ACTION: begin
                c.ptr_rst = b[0];
                c.snap    = b[4];
                case (b[3:1])
                    3'b100:         c.load      = 1'b1;
                    3'b001, 3'b010: c.clr_flags = 1'b1;
                    3'b011:         c.clr_err   = 1'b1;
                    default:        ;
                endcase
            end
            GRP_MODE:  c.wr_mode  = 1'b1;
            GRP_IOCTL: c.wr_ioctl = 1'b1;
            GRP_INDEX: c.wr_index = 1'b1;
            default:   ;
        endcase
        return c;
    endfunction

    function automatic step_res_t next_count(input count_mode_e m,
                                             input logic [CNT_W-1:0] c,
                                             input logic [CNT_W-1:0] p,
                                             input logic up);
        step_res_t r;
        r.val    = c;
        r.carry  = 1'b0;
        r.borrow = 1'b0;
        r.halt   = 1'b0;
        case (m)
            CM_NORMAL, CM_NOREC: begin
                if (up) begin
                    r.val   = c + 1'b1;
                    r.carry = (c == CNT_MAX);
                end else begin
                    r.val    = c - 1'b1;
                    r.borrow = (c == '0);
                end
                r.halt = (m == CM_NOREC) && (r.carry || r.borrow);
            end
            CM_RANGE: begin
                if (up) begin
                    if (c == p) r.carry = 1'b1;
                    else        r.val   = c + 1'b1;
                end else begin
                    if (c == '0) r.borrow = 1'b1;
                    else         r.val    = c - 1'b1;
                end
            end
            default: begin
                if (up) begin
                    if (c == p) begin
                        r.val   = '0;
                        r.carry = 1'b1;
                    end else begin
                        r.val = c + 1'b1;
                    end
                end else begin
                    if (c == '0) begin
                        r.val    = p;
                        r.borrow = 1'b1;
                    end else begin
                        r.val = c - 1'b1;
                    end
                end
            end
        endcase
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input logic borrow,
                                                      input logic carry,
                                                      input logic err,
                                                      input logic dir_up);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[ST_BORROW] = borrow;
        s[ST_CARRY]  = carry;
        s[ST_ERR]    = err;
        s[ST_DIR]    = dir_up;
        return s;
    endfunction

endpackage

// File: rtl/bwc_host_port.sv
module bwc_host_port
    import bwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_ctl,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count_val,
    input  logic [BYTE_W-1:0] status_byte,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  preset_val,
    output logic              host_load,
    output logic              clr_flags,
    output logic              clr_err,
    output count_mode_e       mode,
    output logic              ab_en,
    output logic              idx_load_n,
    output logic              idx_pos
);

    cmd_t             cmd;
    logic             ctl_wr;
    logic             data_wr;
    logic             data_acc;
    logic [PTR_W-1:0] ptr;
    logic [BYTE_W-1:0] preset_b [NBYTES];
    logic [BYTE_W-1:0] latch_b  [NBYTES];
    logic [BYTE_W-1:0] latch_sel;

    assign cmd      = decode_cmd(bus_wdata);
    assign ctl_wr   = bus_wr & bus_ctl;
    assign data_wr  = bus_wr & ~bus_ctl;
    assign data_acc = (bus_wr | bus_rd) & ~bus_ctl;

    assign host_load = ctl_wr & cmd.load;
    assign clr_flags = ctl_wr & cmd.clr_flags;
    assign clr_err   = ctl_wr & cmd.clr_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ctl_wr && cmd.ptr_rst) begin
            ptr <= '0;
        end else if (data_acc) begin
            ptr <= (ptr == PTR_W'(NBYTES - 1)) ? '0 : ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                preset_b[g] <= '0;
            end else if (data_wr && ptr == PTR_W'(g)) begin
                preset_b[g] <= bus_wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                latch_b[g] <= '0;
            end else if (ctl_wr && cmd.snap) begin
                latch_b[g] <= count_val[g*BYTE_W +: BYTE_W];
            end
        end

        assign preset_val[g*BYTE_W +: BYTE_W] = preset_b[g];
    end

    always_comb begin
        latch_sel = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (ptr == PTR_W'(i)) latch_sel = latch_b[i];
        end
    end

    assign bus_rdata = bus_ctl ? status_byte : latch_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= CM_NORMAL;
            ab_en      <= 1'b0;
            idx_load_n <= 1'b0;
            idx_pos    <= 1'b0;
        end else if (ctl_wr) begin
            if (cmd.wr_mode) begin
                mode <= count_mode_e'(cmd.cfg[2:1]);
            end
            if (cmd.wr_ioctl) begin
                ab_en      <= cmd.cfg[0];
                idx_load_n <= cmd.cfg[1];
            end
            if (cmd.wr_index) begin
                idx_pos <= cmd.cfg[1];
            end
        end
    end

endmodule

// File: rtl/bwc_count_core.sv
module bwc_count_core
    import bwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_step,
    input  logic             cnt_up,
    input  logic             hold_rst,
    input  logic             noise_in,
    input  logic             ab_en,
    input  count_mode_e      mode,
    input  logic [CNT_W-1:0] preset_val,
    input  logic             load_any,
    input  logic             clr_flags,
    input  logic             clr_err,
    output logic [CNT_W-1:0] count_val,
    output logic             borrow_flag,
    output logic             carry_flag,
    output logic             err_flag,
    output logic             dir_up
);

    logic      halted;
    logic      step_ok;
    step_res_t res;

    assign step_ok = cnt_step & ab_en & ~hold_rst & ~halted & ~load_any;
    assign res     = next_count(mode, count_val, preset_val, cnt_up);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_val <= '0;
            halted    <= 1'b0;
            dir_up    <= 1'b0;
        end else if (load_any) begin
            count_val <= preset_val;
            halted    <= 1'b0;
        end else if (step_ok) begin
            count_val <= res.val;
            halted    <= res.halt;
            dir_up    <= cnt_up;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_flags) begin
            borrow_flag <= 1'b0;
            carry_flag  <= 1'b0;
        end else if (step_ok) begin
            if (res.borrow) borrow_flag <= 1'b1;
            if (res.carry)  carry_flag  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_err) begin
            err_flag <= 1'b0;
        end else if (noise_in) begin
            err_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/bwc_index_det.sv
module bwc_index_det (
    input  logic clk,
    input  logic rst,
    input  logic index_in,
    input  logic idx_pos,
    output logic idx_evt
);

    logic idx_q;

    always_ff @(posedge clk) begin
        if (rst) idx_q <= 1'b0;
        else     idx_q <= index_in;
    end

    assign idx_evt = idx_pos ? (index_in & ~idx_q) : (~index_in & idx_q);

endmodule

// File: rtl/bytewide_counter_ch.sv
module bytewide_counter_ch
    import bwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_ctl,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cnt_step,
    input  logic              cnt_up,
    input  logic              index_in,
    input  logic              noise_in,
    input  logic              hold_rst
);

    logic [CNT_W-1:0]  count_val;
    logic [CNT_W-1:0]  preset_val;
    logic [BYTE_W-1:0] status_byte;
    logic              host_load;
    logic              idx_evt;
    logic              load_any;
    logic              clr_flags;
    logic              clr_err;
    logic              ab_en;
    logic              idx_load_n;
    logic              idx_pos;
    count_mode_e       mode;
    logic              borrow_flag;
    logic              carry_flag;
    logic              err_flag;
    logic              dir_up;

    assign load_any    = host_load | (idx_evt & ~idx_load_n);
    assign status_byte = pack_status(borrow_flag, carry_flag, err_flag, dir_up);

    bwc_host_port u_port (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_ctl    (bus_ctl),
        .bus_wdata  (bus_wdata),
        .count_val  (count_val),
        .status_byte(status_byte),
        .bus_rdata  (bus_rdata),
        .preset_val (preset_val),
        .host_load  (host_load),
        .clr_flags  (clr_flags),
        .clr_err    (clr_err),
        .mode       (mode),
        .ab_en      (ab_en),
        .idx_load_n (idx_load_n),
        .idx_pos    (idx_pos)
    );

    bwc_count_core u_core (
        .clk        (clk),
        .rst        (rst),
        .cnt_step   (cnt_step),
        .cnt_up     (cnt_up),
        .hold_rst   (hold_rst),
        .noise_in   (noise_in),
        .ab_en      (ab_en),
        .mode       (mode),
        .preset_val (preset_val),
        .load_any   (load_any),
        .clr_flags  (clr_flags),
        .clr_err    (clr_err),
        .count_val  (count_val),
        .borrow_flag(borrow_flag),
        .carry_flag (carry_flag),
        .err_flag   (err_flag),
        .dir_up     (dir_up)
    );

    bwc_index_det u_index (
        .clk     (clk),
        .rst     (rst),
        .index_in(index_in),
        .idx_pos (idx_pos),
        .idx_evt (idx_evt)
    );

endmodule

// File: rtl/bwc_chk.sv
module bwc_chk
    import bwc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count_val,
    input logic [CNT_W-1:0] preset_val,
    input logic             load_any,
    input logic             ab_en,
    input logic             hold_rst,
    input logic             cnt_step,
    input logic             cnt_up,
    input count_mode_e      mode,
    input logic             clr_flags,
    input logic             clr_err,
    input logic             borrow_flag,
    input logic             carry_flag,
    input logic             err_flag
);

    // R3
    load_takes_preset_chk: assert property (@(posedge clk) disable iff (rst)
        load_any |=> count_val == $past(preset_val));

    // R4
    ab_disabled_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!ab_en && !load_any) |=> $stable(count_val));

    // R12
    hold_freezes_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_rst && !load_any) |=> $stable(count_val));

    // R6
    range_top_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_RANGE && cnt_step && cnt_up && count_val == preset_val && !load_any)
        |=> $stable(count_val));

    // R9
    flags_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        clr_flags |=> (!borrow_flag && !carry_flag));

    // R9
    err_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        clr_err |=> !err_flag);

endmodule

bind bytewide_counter_ch bwc_chk u_chk (.*);

// File: tb/bytewide_counter_ch_tb.sv
module bytewide_counter_ch_tb;

    localparam logic [23:0] MAXV = 24'hFFFFFF;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr, bus_rd, bus_ctl;
    logic [7:0] bus_wdata, bus_rdata;
    logic       cnt_step, cnt_up, index_in, noise_in, hold_rst;

    int checks = 0;
    int errors = 0;

    logic [23:0] m_cnt, m_pre;
    logic [1:0]  m_mode;
    logic        m_c, m_b, m_e, m_dir, m_halt, m_ab, m_hold;

    always #5 clk = ~clk;

    bytewide_counter_ch u_dut (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_ctl  (bus_ctl),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt_step (cnt_step),
        .cnt_up   (cnt_up),
        .index_in (index_in),
        .noise_in (noise_in),
        .hold_rst (hold_rst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {2'b00, m_dir, m_e, 2'b00, m_c, m_b};
    endfunction

    task automatic ctl_wr(input logic [7:0] b);
        @(negedge clk);
        bus_ctl = 1'b1; bus_wr = 1'b1; bus_wdata = b;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic data_wr(input logic [7:0] b);
        @(negedge clk);
        bus_ctl = 1'b0; bus_wr = 1'b1; bus_wdata = b;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] v);
        @(negedge clk);
        bus_ctl = 1'b0; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_cnt(output logic [23:0] v);
        logic [7:0] b;
        ctl_wr(8'h11);
        for (int i = 0; i < 3; i++) begin
            rd_byte(b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic read_stat(output logic [7:0] v);
        @(negedge clk);
        bus_ctl = 1'b1;
        #1 v = bus_rdata;
    endtask

    task automatic set_preset(input logic [23:0] v);
        ctl_wr(8'h01);
        for (int i = 0; i < 3; i++) data_wr(v[i*8 +: 8]);
        m_pre = v;
    endtask

    task automatic load_cnt();
        ctl_wr(8'h08);
        m_cnt = m_pre; m_halt = 1'b0;
    endtask

    task automatic load_value(input logic [23:0] v, input logic [23:0] p);
        set_preset(v);
        load_cnt();
        set_preset(p);
    endtask

    task automatic set_mode(input logic [1:0] md);
        ctl_wr(8'h20 | {5'b0, md, 1'b0});
        m_mode = md;
    endtask

    task automatic clr_flags();
        ctl_wr(8'h02);
        m_c = 1'b0; m_b = 1'b0;
    endtask

    task automatic mstep(input logic up);
        if (!m_ab || m_hold || m_halt) return;
        m_dir = up;
        case (m_mode)
            2'd0, 2'd2: begin
                if (up) begin
                    if (m_cnt == MAXV) m_c = 1'b1;
                    m_cnt = m_cnt + 24'd1;
                    if (m_mode == 2'd2 && m_cnt == 24'd0) m_halt = 1'b1;
                end else begin
                    if (m_cnt == 24'd0) m_b = 1'b1;
                    m_cnt = m_cnt - 24'd1;
                    if (m_mode == 2'd2 && m_cnt == MAXV) m_halt = 1'b1;
                end
            end
            2'd1: begin
                if (up) begin
                    if (m_cnt == m_pre) m_c = 1'b1;
                    else m_cnt = m_cnt + 24'd1;
                end else begin
                    if (m_cnt == 24'd0) m_b = 1'b1;
                    else m_cnt = m_cnt - 24'd1;
                end
            end
            default: begin
                if (up) begin
                    if (m_cnt == m_pre) begin m_cnt = 24'd0; m_c = 1'b1; end
                    else m_cnt = m_cnt + 24'd1;
                end else begin
                    if (m_cnt == 24'd0) begin m_cnt = m_pre; m_b = 1'b1; end
                    else m_cnt = m_cnt - 24'd1;
                end
            end
        endcase
    endtask

    task automatic steps(input logic up, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_step = 1'b1; cnt_up = up;
            @(negedge clk);
            cnt_step = 1'b0;
            mstep(up);
        end
    endtask

    task automatic set_index(input logic v);
        @(negedge clk);
        index_in = v;
        @(negedge clk);
    endtask

    task automatic expect_cnt(input string tag);
        logic [23:0] v;
        read_cnt(v);
        check(tag, {8'h0, v}, {8'h0, m_cnt});
    endtask

    task automatic expect_stat(input string tag);
        logic [7:0] s;
        read_stat(s);
        check(tag, {24'h0, s}, {24'h0, exp_status()});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [23:0] p, st;
        logic [1:0] md;
        int n, sel;
        string mtag [4];
        mtag[0] = "R5"; mtag[1] = "R6"; mtag[2] = "R7"; mtag[3] = "R8";
        void'($urandom(32'd1357));

        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_ctl = 0; bus_wdata = 0;
        cnt_step = 0; cnt_up = 0; index_in = 0; noise_in = 0; hold_rst = 0;
        m_cnt = 0; m_pre = 0; m_mode = 0; m_c = 0; m_b = 0; m_e = 0;
        m_dir = 0; m_halt = 0; m_ab = 0; m_hold = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        expect_stat("R1 status");
        expect_cnt("R1 counter");

        // R4: count inputs disabled after reset
        steps(1'b1, 3);
        expect_cnt("R4 disabled strobes");
        ctl_wr(8'h41); m_ab = 1'b1;

        // R3: load from preset
        set_preset(24'hA1B2C3);
        load_cnt();
        expect_cnt("R3 preset transfer");

        // R2: byte order, pointer reset, snapshot hold
        ctl_wr(8'h11);
        rd_byte(b); check("R2 byte0", {24'h0, b}, 32'hC3);
        rd_byte(b); check("R2 byte1", {24'h0, b}, 32'hB2);
        ctl_wr(8'h01);
        rd_byte(b); check("R2 pointer reset", {24'h0, b}, 32'hC3);
        steps(1'b1, 1);
        ctl_wr(8'h01);
        rd_byte(b); check("R2 latch holds", {24'h0, b}, 32'hC3);
        expect_cnt("R5 up count");

        // R10: direction bit
        expect_stat("R10 direction up");
        steps(1'b0, 1);
        expect_stat("R10 direction down");

        // R5: normal wrap both ways
        load_value(MAXV - 24'd1, 24'd0);
        steps(1'b1, 2);
        expect_cnt("R5 up wrap");
        expect_stat("R5 carry");
        clr_flags();
        expect_stat("R9 clear 0x02");
        steps(1'b0, 1);
        expect_cnt("R5 down wrap");
        expect_stat("R5 borrow");
        ctl_wr(8'h04); m_c = 0; m_b = 0;
        expect_stat("R9 clear 0x04");

        // R10/R9: noise error flag
        @(negedge clk); noise_in = 1'b1;
        @(negedge clk); noise_in = 1'b0;
        m_e = 1'b1;
        expect_stat("R10 error set");
        clr_flags();
        expect_stat("R9 error kept by flag clear");
        ctl_wr(8'h06); m_e = 1'b0;
        expect_stat("R9 error cleared");

        // R6: range limit
        set_mode(2'd1);
        load_value(24'd3, 24'd5);
        clr_flags();
        steps(1'b1, 4);
        expect_cnt("R6 stop at preset");
        expect_stat("R6 carry");
        clr_flags();
        steps(1'b0, 7);
        expect_cnt("R6 stop at zero");
        expect_stat("R6 borrow");

        // R7: non-recycle
        set_mode(2'd2);
        load_value(MAXV - 24'd1, 24'd100);
        clr_flags();
        steps(1'b1, 4);
        expect_cnt("R7 halted after wrap");
        expect_stat("R7 carry");
        load_cnt();
        steps(1'b1, 1);
        expect_cnt("R7 resumes after load");

        // R8: modulo-n
        set_mode(2'd3);
        load_value(24'd2, 24'd4);
        clr_flags();
        steps(1'b1, 3);
        expect_cnt("R8 up past preset");
        steps(1'b0, 1);
        expect_cnt("R8 down past zero");
        expect_stat("R8 flags");

        // R12: hold input
        set_mode(2'd0);
        @(negedge clk); hold_rst = 1'b1; m_hold = 1'b1;
        steps(1'b1, 3);
        @(negedge clk); hold_rst = 1'b0; m_hold = 1'b0;
        expect_cnt("R12 hold freezes");

        // R11: index loads
        set_preset(24'h345678);
        set_index(1'b1);
        expect_cnt("R11 negative polarity ignores rise");
        set_index(1'b0);
        m_cnt = m_pre; m_halt = 1'b0;
        expect_cnt("R11 falling edge loads");
        ctl_wr(8'h62);
        steps(1'b1, 1);
        set_index(1'b1);
        m_cnt = m_pre; m_halt = 1'b0;
        expect_cnt("R11 rising edge loads");
        set_index(1'b0);
        ctl_wr(8'h43);
        steps(1'b1, 2);
        set_index(1'b1);
        expect_cnt("R11 index load disabled");
        set_index(1'b0);
        ctl_wr(8'h41);

        // random mix over all modes
        for (int it = 0; it < 24; it++) begin
            md = 2'($urandom % 4);
            if ($urandom % 2) p = 24'($urandom % 16 + 2);
            else              p = 24'($urandom);
            if (md == 2'd1 || md == 2'd3) begin
                st = 24'($urandom % (32'(p) + 1));
            end else begin
                sel = int'($urandom % 3);
                if (sel == 0)      st = 24'($urandom % 4);
                else if (sel == 1) st = MAXV - 24'($urandom % 4);
                else               st = 24'($urandom);
            end
            set_mode(md);
            load_value(st, p);
            clr_flags();
            n = int'($urandom % 10);
            for (int k = 0; k < n; k++) steps(1'($urandom % 2), 1);
            expect_cnt({mtag[md], " random count"});
            expect_stat({mtag[md], " random flags"});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule